// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address by reading a three-level radix page table from memory. A request carries the virtual address, a write flag and a kernel-mode flag. The walker first classifies the address: a malformed upper part, a user access above the user segment, or a kernel access to the direct-mapped physical segment all finish at once, with no memory read. Every other address is translated by reading one 8-byte entry per level. The first read uses the page table base input. Each later read uses the frame number returned by the previous entry.

Memory is reached through a simple read port: a one-cycle request pulse with an address, then a response pulse with 64 bits of data at any later cycle. Only one read is outstanding at a time. Completion is reported by a one-cycle pulse together with a fault code, the physical address and the leaf entry's rights. The block holds no cached entries. Fault handling belongs to the requester.

Top module: `ptw_walker`

## Requirements
- R1: On a successful translation, pa_o[12:0] equals va[12:0], and pa_o[44:13] is the leaf entry's frame number taken from entry bits [63:32].
- R2: The virtual address bits split into three 10-bit indices: va[42:33] for the first read, va[32:23] for the second and va[22:13] for the third. Each read address is {base, index, 3'b000}. The first base is ptbr_i. Each later base is bits [63:32] of the entry just read.
- R3: An entry with bit 0 clear, at any level, ends the walk with fault code 1 (not present), pa_o = 0 and rights_o = 0. No further read is issued.
- R4: The leaf rights are entry bits [11:8]: bit 8 kernel-read, bit 9 user-read, bit 10 kernel-write, bit 11 user-write. A read needs the read bit of the current mode and a write needs the write bit of that mode. If the needed bit is missing, the result is fault code 2 with pa_o = 0. rights_o reports bits [11:8] of every valid leaf entry.
- R5: If va[63:43] are not all equal to va[42], the result is fault code 3 (bad address). This check takes priority over every other check, and no memory read is made.
- R6: In kernel mode, an address with va[42:41] = 2'b10 completes with fault code 0, pa_o = {4'b0, va[40:0]} and rights_o = 4'b0101, with no memory read.
- R7: In user mode, an address that is well formed but has va[42] = 1 completes with fault code 2, pa_o = 0 and rights_o = 0, with no memory read.
- R8: A request is taken only while req_ready_o is high. A request presented while a walk is in progress has no effect. mem_req_o is a single-cycle pulse, and the next pulse comes only after the previous response.
- R9: Each accepted request produces exactly one done_o pulse, one cycle wide.
- R10: After reset, req_ready_o is 1, and done_o and mem_req_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ptbr_i | input | 32 | Frame number of the first-level table |
| req_valid_i | input | 1 | Translation request strobe |
| req_ready_o | output | 1 | Walker idle; a request is taken this cycle |
| req_va_i | input | 64 | Virtual address |
| req_write_i | input | 1 | 1 = write access, 0 = read access |
| req_kernel_i | input | 1 | 1 = kernel mode, 0 = user mode |
| mem_req_o | output | 1 | Read request pulse |
| mem_addr_o | output | 45 | Byte address of the entry to read |
| mem_rsp_valid_i | input | 1 | Read data valid pulse |
| mem_rsp_data_i | input | 64 | Entry read from memory |
| done_o | output | 1 | Completion pulse |
| fault_o | output | 2 | 0 none, 1 not present, 2 protection, 3 bad address |
| pa_o | output | 45 | Physical address (0 on fault) |
| rights_o | output | 4 | Leaf rights {user-write, kernel-write, user-read, kernel-read} |

## Verification
The assertions check the protocol shape on every cycle: read pulses that are single and only issued while busy, one-cycle completion pulses, offset pass-through on any successful result, and no read after an immediately rejected address. Whether each read address is built from the right index and base, whether the correct fault is chosen in the right priority, and whether the rights decode is correct can only be shown by the bench. The bench walks a page table that it computes arithmetically, sweeping several hundred addresses across both modes, both access types and varied memory latency, and it also covers a request arriving while the walker is busy.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

   typedef enum logic [1:0] {
      FLT_NONE   = 2'd0,
      FLT_ABSENT = 2'd1,
      FLT_PROT   = 2'd2,
      FLT_BADVA  = 2'd3
   } flt_e;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_L1    = 3'd1,
      ST_L2    = 3'd2,
      ST_L3    = 3'd3,
      ST_DONE  = 3'd4,
      ST_FAULT = 3'd5
   } walk_st_e;

   localparam int unsigned NUM_LEVELS = 3;

endpackage

// File: rtl/ptw_seg_decode.sv
module ptw_seg_decode #(
   parameter int unsigned VA_W     = 64,
   parameter int unsigned SIG_BITS = 43,
   parameter int unsigned PA_W     = 45
) (
   input  logic [VA_W-1:0] va_i,
   input  logic            kernel_i,
   output logic            bad_o,
   output logic            user_block_o,
   output logic            direct_o,
   output logic [PA_W-1:0] direct_pa_o
);
   localparam int unsigned EXT_W    = VA_W - SIG_BITS;
   localparam int unsigned DIRECT_W = SIG_BITS - 2;

   if (EXT_W < 1) begin : g_chk_ext
      $error("ptw_seg_decode: VA_W must exceed SIG_BITS");
   end
   if (PA_W < DIRECT_W) begin : g_chk_pa
      $error("ptw_seg_decode: PA_W too narrow for direct segment");
   end

   logic [EXT_W-1:0] upper;
   logic [1:0]       seg_sel;

   always_comb begin
      upper        = va_i[VA_W-1:SIG_BITS];
      seg_sel      = va_i[SIG_BITS-1:SIG_BITS-2];
      bad_o        = (upper != {EXT_W{va_i[SIG_BITS-1]}});
      user_block_o = !bad_o && !kernel_i && va_i[SIG_BITS-1];
      direct_o     = !bad_o && kernel_i && (seg_sel == 2'b10);
      direct_pa_o  = '0;
      direct_pa_o[DIRECT_W-1:0] = va_i[DIRECT_W-1:0];
   end

endmodule

// File: rtl/ptw_index_sel.sv
module ptw_index_sel #(
   parameter int unsigned VA_W      = 64,
   parameter int unsigned IDX_BITS  = 10,
   parameter int unsigned PAGE_BITS = 13,
   parameter int unsigned LEVELS    = 3
) (
   input  logic [VA_W-1:0]     va_i,
   input  logic [1:0]          level_i,
   output logic [IDX_BITS-1:0] idx_o
);
   logic [IDX_BITS-1:0] idx_by_lvl [LEVELS];

   for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
      localparam int unsigned LSB = PAGE_BITS + (LEVELS - 1 - g) * IDX_BITS;
      assign idx_by_lvl[g] = va_i[LSB +: IDX_BITS];
   end

   always_comb begin
      idx_o = idx_by_lvl[0];
      for (int i = 0; i < LEVELS; i++) begin
         if (level_i == 2'(i)) idx_o = idx_by_lvl[i];
      end
   end

endmodule

// File: rtl/ptw_rights_check.sv
module ptw_rights_check #(
   parameter int unsigned RIGHTS_W = 4
) (
   input  logic [RIGHTS_W-1:0] rights_i,
   input  logic                write_i,
   input  logic                kernel_i,
   output logic                allow_o
);
   if (RIGHTS_W != 4) begin : g_chk_w
      $error("ptw_rights_check: rights field must be 4 bits");
   end

   logic [1:0] sel;

   always_comb begin
      sel     = {write_i, !kernel_i};
      allow_o = rights_i[sel];
   end

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
   import ptw_pkg::*;
#(
   parameter int unsigned VA_W       = 64,
   parameter int unsigned IDX_BITS   = 10,
   parameter int unsigned PAGE_BITS  = 13,
   parameter int unsigned PPN_W      = 32,
   parameter int unsigned DATA_W     = 64,
   parameter int unsigned RIGHTS_LSB = 8,
   parameter int unsigned RIGHTS_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PPN_W-1:0]  ptbr_i,
   input  logic              req_valid_i,
   output logic              req_ready_o,
   input  logic [VA_W-1:0]   req_va_i,
   input  logic              req_write_i,
   input  logic              req_kernel_i,
   output logic              mem_req_o,
   output logic [PPN_W+PAGE_BITS-1:0] mem_addr_o,
   input  logic              mem_rsp_valid_i,
   input  logic [DATA_W-1:0] mem_rsp_data_i,
   output logic              done_o,
   output logic [1:0]        fault_o,
   output logic [PPN_W+PAGE_BITS-1:0] pa_o,
   output logic [RIGHTS_W-1:0] rights_o
);
   localparam int unsigned PA_W      = PPN_W + PAGE_BITS;
   localparam int unsigned SIG_BITS  = NUM_LEVELS * IDX_BITS + PAGE_BITS;
   localparam int unsigned ENT_SHIFT = PAGE_BITS - IDX_BITS;
   localparam int unsigned PPN_LSB   = DATA_W - PPN_W;
   localparam logic [RIGHTS_W-1:0] DIRECT_RIGHTS = RIGHTS_W'(4'b0101);

   if (ENT_SHIFT != 3) begin : g_chk_entry
      $error("ptw_walker: a table page must hold 8-byte entries");
   end
   if (SIG_BITS >= VA_W) begin : g_chk_va
      $error("ptw_walker: virtual address too narrow for the tree");
   end
   if (RIGHTS_LSB + RIGHTS_W > PPN_LSB) begin : g_chk_fields
      $error("ptw_walker: rights field overlaps frame number");
   end

   walk_st_e            state_q;
   logic [PPN_W-1:0]    base_q;
   logic [VA_W-1:0]     va_q;
   logic                wr_q;
   logic                kern_q;
   logic                issue_q;
   flt_e                fault_q;
   logic [PA_W-1:0]     pa_q;
   logic [RIGHTS_W-1:0] rights_q;

   logic                seg_bad, seg_user_block, seg_direct;
   logic [PA_W-1:0]     seg_direct_pa;
   logic [1:0]          level;
   logic [IDX_BITS-1:0] idx;
   logic                allow;
   logic                rsp_take;
   logic [PPN_W-1:0]    rsp_ppn;
   logic [RIGHTS_W-1:0] rsp_rights;

   ptw_seg_decode #(
      .VA_W(VA_W), .SIG_BITS(SIG_BITS), .PA_W(PA_W)
   ) seg_i (
      .va_i(req_va_i), .kernel_i(req_kernel_i),
      .bad_o(seg_bad), .user_block_o(seg_user_block),
      .direct_o(seg_direct), .direct_pa_o(seg_direct_pa)
   );

   always_comb begin
      case (state_q)
         ST_L2:   level = 2'd1;
         ST_L3:   level = 2'd2;
         default: level = 2'd0;
      endcase
   end

   ptw_index_sel #(
      .VA_W(VA_W), .IDX_BITS(IDX_BITS), .PAGE_BITS(PAGE_BITS),
      .LEVELS(NUM_LEVELS)
   ) idx_i (
      .va_i(va_q), .level_i(level), .idx_o(idx)
   );

   assign rsp_ppn    = mem_rsp_data_i[DATA_W-1:PPN_LSB];
   assign rsp_rights = mem_rsp_data_i[RIGHTS_LSB +: RIGHTS_W];

   ptw_rights_check #(.RIGHTS_W(RIGHTS_W)) rights_i (
      .rights_i(rsp_rights), .write_i(wr_q), .kernel_i(kern_q),
      .allow_o(allow)
   );

   assign rsp_take = !issue_q && mem_rsp_valid_i &&
                     (state_q == ST_L1 || state_q == ST_L2 || state_q == ST_L3);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         base_q   <= '0;
         va_q     <= '0;
         wr_q     <= 1'b0;
         kern_q   <= 1'b0;
         issue_q  <= 1'b0;
         fault_q  <= FLT_NONE;
         pa_q     <= '0;
         rights_q <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (req_valid_i) begin
                  va_q     <= req_va_i;
                  wr_q     <= req_write_i;
                  kern_q   <= req_kernel_i;
                  pa_q     <= '0;
                  rights_q <= '0;
                  fault_q  <= FLT_NONE;
                  if (seg_bad) begin
                     fault_q <= FLT_BADVA;
                     state_q <= ST_FAULT;
                  end else if (seg_user_block) begin
                     fault_q <= FLT_PROT;
                     state_q <= ST_FAULT;
                  end else if (seg_direct) begin
                     pa_q     <= seg_direct_pa;
                     rights_q <= DIRECT_RIGHTS;
                     state_q  <= ST_DONE;
                  end else begin
                     base_q  <= ptbr_i;
                     issue_q <= 1'b1;
                     state_q <= ST_L1;
                  end
               end
            end
            ST_L1, ST_L2, ST_L3: begin
               issue_q <= 1'b0;
               if (rsp_take) begin
                  if (!mem_rsp_data_i[0]) begin
                     fault_q <= FLT_ABSENT;
                     state_q <= ST_FAULT;
                  end else if (state_q == ST_L3) begin
                     rights_q <= rsp_rights;
                     if (allow) begin
                        pa_q    <= {rsp_ppn, va_q[PAGE_BITS-1:0]};
                        state_q <= ST_DONE;
                     end else begin
                        fault_q <= FLT_PROT;
                        state_q <= ST_FAULT;
                     end
                  end else begin
                     base_q  <= rsp_ppn;
                     issue_q <= 1'b1;
                     state_q <= (state_q == ST_L1) ? ST_L2 : ST_L3;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready_o = (state_q == ST_IDLE);
   assign mem_req_o   = issue_q;
   assign mem_addr_o  = {base_q, idx, {ENT_SHIFT{1'b0}}};
   assign done_o      = (state_q == ST_DONE) || (state_q == ST_FAULT);
   assign fault_o     = fault_q;
   assign pa_o        = pa_q;
   assign rights_o    = rights_q;

   assert_single_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |=> !mem_req_o);

   assert_read_when_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |-> !req_ready_o && !done_o);

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_offset_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && fault_o == FLT_NONE) |-> pa_o[PAGE_BITS-1:0] == va_q[PAGE_BITS-1:0]);

   assert_bad_no_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready_o && req_valid_i && seg_bad) |=> !mem_req_o && done_o);

endmodule

// File: tb/ptw_walker_tb_top.sv
module ptw_walker_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] ptbr = 32'h0000_0123;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [63:0] req_va = '0;
   logic        req_write = 1'b0;
   logic        req_kernel = 1'b0;
   logic        mem_req;
   logic [44:0] mem_addr;
   logic        rsp_valid = 1'b0;
   logic [63:0] rsp_data = '0;
   logic        done;
   logic [1:0]  fault;
   logic [44:0] pa;
   logic [3:0]  rights;

   int tests = 0;
   int fails = 0;
   int cycles = 0;
   int lat = 1;

   always #5 clk = ~clk;

   ptw_walker dut_i (
      .clk(clk), .rst_n(rst_n), .ptbr_i(ptbr),
      .req_valid_i(req_valid), .req_ready_o(req_ready),
      .req_va_i(req_va), .req_write_i(req_write), .req_kernel_i(req_kernel),
      .mem_req_o(mem_req), .mem_addr_o(mem_addr),
      .mem_rsp_valid_i(rsp_valid), .mem_rsp_data_i(rsp_data),
      .done_o(done), .fault_o(fault), .pa_o(pa), .rights_o(rights)
   );

   // Page table content is a pure function of the entry address.
   function automatic logic [63:0] pte(input logic [44:0] a);
      logic [31:0] h;
      h = a[34:3] * 32'h9E37_79B1;
      h = h ^ a[44:13];
      return {h ^ 32'h5A5A_0000, 20'b0, h[7:4], 7'b0, (a[6:3] != 4'hF)};
   endfunction

   // Memory responder and read log.
   logic        pend = 1'b0;
   int          cnt = 0;
   logic [44:0] paddr = '0;
   int          rd_total = 0;
   logic [44:0] rd_log [8];

   always @(posedge clk) begin
      rsp_valid <= 1'b0;
      if (mem_req) begin
         pend  <= 1'b1;
         cnt   <= lat - 1;
         paddr <= mem_addr;
         rd_log[rd_total % 8] <= mem_addr;
         rd_total <= rd_total + 1;
      end else if (pend) begin
         if (cnt == 0) begin
            rsp_valid <= 1'b1;
            rsp_data  <= pte(paddr);
            pend      <= 1'b0;
         end else begin
            cnt <= cnt - 1;
         end
      end
   end

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         fails = fails + 1;
         $display("FAIL watchdog expired: actual hung, expected finish");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Requirement model.
   task automatic model(input logic [63:0] va, input logic wr, input logic kern,
                        output logic [1:0] ef, output logic [44:0] epa,
                        output logic [3:0] er, output int nrd,
                        output logic [44:0] ea [3]);
      logic [31:0] base;
      logic [63:0] e;
      logic [9:0]  ix;
      ef = 2'd0; epa = '0; er = '0; nrd = 0;
      for (int i = 0; i < 3; i++) ea[i] = '0;
      if (va[63:43] != {21{va[42]}}) begin
         ef = 2'd3; return;
      end
      if (!kern && va[42]) begin
         ef = 2'd2; return;
      end
      if (kern && va[42:41] == 2'b10) begin
         epa = {4'b0, va[40:0]}; er = 4'b0101; return;
      end
      base = ptbr;
      for (int l = 0; l < 3; l++) begin
         ix = va[33 - 10*l +: 10];
         ea[l] = {base, ix, 3'b000};
         nrd = l + 1;
         e = pte(ea[l]);
         if (!e[0]) begin
            ef = 2'd1; return;
         end
         base = e[63:32];
         if (l == 2) begin
            er = e[11:8];
            if (e[8 + {wr, !kern}]) epa = {e[63:32], va[12:0]};
            else ef = 2'd2;
         end
      end
   endtask

   task automatic run(input logic [63:0] va, input logic wr, input logic kern);
      logic [1:0]  ef;
      logic [44:0] epa;
      logic [3:0]  er;
      int          nrd, start, n;
      logic [44:0] ea [3];
      model(va, wr, kern, ef, epa, er, nrd, ea);
      @(negedge clk);
      start = rd_total;
      req_va = va; req_write = wr; req_kernel = kern; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      n = 0;
      while (!done && n < 80) begin
         @(negedge clk);
         n++;
      end
      check("R9 done pulse seen", done, 1'b1);
      check(ef == 2'd1 ? "R3 fault code" : ef == 2'd3 ? "R5 fault code" :
            (ef == 2'd2 && nrd == 0) ? "R7 fault code" : "R4 fault code", fault, ef);
      check(ef == 2'd0 ? (nrd == 0 ? "R6 direct pa" : "R1 pa") : "R3 pa zero on fault", pa, epa);
      check("R4 rights", rights, er);
      check(nrd == 0 ? "R5 no reads" : "R2 read count", rd_total - start, nrd);
      for (int i = 0; i < nrd; i++)
         check("R2 read address", rd_log[(start + i) % 8], ea[i]);
      @(negedge clk);
      check("R9 single-cycle done", done, 1'b0);
   endtask

   initial begin
      logic [42:0] s;
      logic [63:0] va;
      int start;
      repeat (3) @(negedge clk);
      check("R10 ready after reset", req_ready, 1'b1);
      check("R10 done low after reset", done, 1'b0);
      check("R10 no read after reset", mem_req, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);

      // Bad address patterns (R5), checked in both modes.
      run(64'h0001_0000_0000_0000, 1'b0, 1'b1);
      run(64'hFFFF_F000_0000_0000 ^ 64'h0000_0800_0000_0000, 1'b0, 1'b0);
      run(64'h8000_0000_0000_0000, 1'b1, 1'b1);
      // Direct kernel segment (R6) and user attempts at it (R7).
      run(64'hFFFF_FC12_3456_789A, 1'b1, 1'b1);
      run(64'hFFFF_FC12_3456_789A, 1'b0, 1'b0);
      run(64'hFFFF_FE00_0000_2000, 1'b0, 1'b0);
      // Kernel walk in the upper segment.
      run(64'hFFFF_FE00_0000_2000, 1'b0, 1'b1);

      // Sweep over indices, offsets, modes, access kinds and latencies.
      for (int k = 0; k < 400; k++) begin
         lat = (k % 3) + 1;
         s = {10'((k * 37) % 1024), 10'((k * 53 + 7) % 1024),
              10'((k * 71 + 3) % 1024), 13'((k * 977) % 8192)};
         va = {{21{s[42]}}, s};
         run(va, k[0], k[1]);
      end

      // R8: a request during a walk is ignored.
      lat = 3;
      s = {10'd5, 10'd6, 10'd7, 13'h123};
      @(negedge clk);
      start = rd_total;
      req_va = {21'b0, s}; req_write = 1'b0; req_kernel = 1'b1; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      check("R8 ready low while busy", req_ready, 1'b0);
      req_va = 64'h0001_0000_0000_0000; req_valid = 1'b1;
      @(negedge clk);
      check("R8 busy request not completed", done, 1'b0);
      req_valid = 1'b0;
      begin
         logic [1:0]  ef;
         logic [44:0] epa;
         logic [3:0]  er;
         int          nrd, n;
         logic [44:0] ea [3];
         model({21'b0, s}, 1'b0, 1'b1, ef, epa, er, nrd, ea);
         n = 0;
         while (!done && n < 80) begin
            @(negedge clk);
            n++;
         end
         check("R8 first request result", fault, ef);
         check("R8 first request pa", pa, epa);
         check("R8 read count", rd_total - start, nrd);
         n = 0;
         for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (done) n++;
         end
         check("R8 no completion for ignored request", n, 0);
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule